// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Model

This block is a synthesizable model of a byte-organised serial EEPROM that answers as a target on a two-wire bus. The serial clock and data lines reach it already synchronised to a faster system clock. It pulls the data line low through an open-drain output enable, and it never drives the line high. One parameter picks the array size, from 128 to 2048 bytes. The address width, the page size and the number of device-select bits that are compared with the strap pins all follow from that choice.

A bus master addresses the block with a device byte. For a write, it follows with a word address and then one or more data bytes. The bytes collect in a page buffer and are committed to the array at the STOP. After the commit the block stays deaf to the bus for a write cycle, so the master can poll for completion by sending address bytes until one is acknowledged. Reads come in three forms: from the internal address counter, from a fresh address loaded by a dummy write, or as a sequence of bytes that runs across the whole array.

Top module: `eeprom_slave`

## Requirements
- R1: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. A START received partway through a byte abandons that byte and begins a new device-address byte.
- R2: The first byte after a START is acknowledged only if its top four bits are 1010 and its compared select bits equal the strap pins. When it is not acknowledged, the block ignores every byte until the next START.
- R3: The device byte is laid out as {1010, s2, s1, s0, rw}, with rw = 1 for a read. Select bit sk is compared with strap pin k only when k is at least max(0, addrWidth-8). Each select bit below that limit becomes word-address bit 8+k. At SIZE_SEL=2 this means s2 and s1 are compared and s0 is address bit 8.
- R4: The block acknowledges each received address or data byte by pulling SDA low from the SCL falling edge after bit 8 until the falling edge of the ninth clock.
- R5: A byte write stores its data byte at the STOP that ends it, and a later read of that address returns it.
- R6: Pages are 8 bytes when SIZE_SEL is below 2 and 16 bytes otherwise. During a write only the low page bits of the address advance, so data beyond the page end wraps to the page start and overwrites it.
- R7: After a STOP that commits data, the block acknowledges no address for WR_CYCLES system clocks. After that, a new START and device byte are acknowledged.
- R8: While wp is high, a write changes no array byte, although its bytes are still acknowledged.
- R9: The address counter holds the last accessed address plus one. A read with no address phase returns the byte at the counter. On reads, the counter wraps from the last array byte to byte 0.
- R10: A random read is a device write byte and a word address, followed by a repeated START and a device read byte. It returns the byte at that address.
- R11: In a sequential read, each master ACK (SDA low on the ninth clock) brings the next byte, continuing across page boundaries. A master NACK releases SDA and ends the read.
- R12: A STOP that arrives before any data byte starts no write cycle, but it keeps the loaded word address.
- R13: Data bytes that are followed by a repeated START rather than a STOP are discarded and start no write cycle.
- R14: During and after reset, with the bus idle, sdaOe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| scl | input | 1 | Synchronised serial clock |
| sdaIn | input | 1 | Synchronised level of the shared data line |
| pinA | input | 3 | Strap pins compared with the device-select bits |
| wp | input | 1 | Write protect; high blocks array updates |
| sdaOe | output | 1 | High pulls the data line low |

## Verification
The bench builds the block with SIZE_SEL=2, which gives a 512-byte array with 16-byte pages, two compared strap pins and one select bit used as address bit 8. With that build, the read wrap from 0x1FF to 0x000 takes only one random read, and the page-bit aliasing check needs only two addresses that differ in bit 8. WR_CYCLES is set to 400 system clocks. That is long enough that an address byte sent right after a STOP lands inside the busy window, and short enough that waiting it out costs little.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEVACK,
    ST_WADR,
    ST_WADRACK,
    ST_WDAT,
    ST_WDATACK,
    ST_RDAT,
    ST_RACK,
    ST_BUSY
  } state_t;

  // strobes from control to datapath, one cycle wide each
  typedef struct packed {
    logic rxShift;   // shift sdaIn into the receive register
    logic capDev;    // keep select bits of an accepted device byte
    logic clrBuf;    // drop any pending page data
    logic loadAddr;  // load word address counter
    logic bufWrite;  // place received byte into page buffer
    logic commit;    // move page buffer into array
    logic rdLoad;    // fetch byte at counter, advance counter
    logic txShift;   // advance transmit register by one bit
  } strobe_t;

  function automatic int addrBits(input int sizeSel);
    return 7 + sizeSel;
  endfunction

  function automatic int pageBits(input int sizeSel);
    return (sizeSel < 2) ? 3 : 4;
  endfunction

endpackage

// File: rtl/eeprom_dpath.sv
module eeprom_dpath
  import eeprom_pkg::*;
#(
  parameter int SIZE_SEL = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strb,
  input  logic       sdaIn,
  input  logic [2:0] pinA,
  input  logic       wp,
  output logic       devMatch,
  output logic       devRead,
  output logic       txBit,
  output logic       pendAny
);

  localparam int AW    = addrBits(SIZE_SEL);
  localparam int PW    = pageBits(SIZE_SEL);
  localparam int PAGE  = 1 << PW;
  localparam int DEPTH = 1 << AW;
  localparam int NPB   = (AW > 8) ? (AW - 8) : 0;
  localparam logic [2:0] CMP_MASK = 3'(3'b111 << NPB);

  logic [7:0]    rxReg;
  logic [7:0]    txReg;
  logic [2:0]    devSel;
  logic [AW-1:0] addr;
  logic [PAGE-1:0] pValid;
  logic [7:0]    pBuf [PAGE];
  logic [7:0]    mem  [DEPTH];

  logic [PW-1:0]    lowNext;
  logic [AW-PW-1:0] rowNow;

  assign lowNext = addr[PW-1:0] + 1'b1;
  assign rowNow  = addr[AW-1:PW];

  assign devMatch = (rxReg[7:4] == 4'b1010) &&
                    (((rxReg[3:1] ^ pinA) & CMP_MASK) == 3'b000);
  assign devRead  = rxReg[0];
  assign txBit    = txReg[7];
  assign pendAny  = |pValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReg  <= '0;
      txReg  <= 8'hFF;
      devSel <= '0;
      addr   <= '0;
      pValid <= '0;
    end else begin
      if (strb.rxShift) rxReg <= {rxReg[6:0], sdaIn};
      if (strb.capDev)  devSel <= rxReg[3:1];
      if (strb.loadAddr) addr <= AW'({devSel, rxReg});
      if (strb.bufWrite) begin
        pValid[addr[PW-1:0]] <= 1'b1;
        addr <= {rowNow, lowNext};
      end
      if (strb.clrBuf || strb.commit) pValid <= '0;
      if (strb.rdLoad) begin
        txReg <= mem[addr];
        addr  <= addr + 1'b1;
      end else if (strb.txShift) begin
        txReg <= {txReg[6:0], 1'b1};
      end
    end
  end

  // page buffer and array carry no reset
  always_ff @(posedge clk) begin
    if (strb.bufWrite) pBuf[addr[PW-1:0]] <= rxReg;
    if (strb.commit && !wp) begin
      for (int i = 0; i < PAGE; i++) begin
        if (pValid[i]) mem[{rowNow, PW'(i)}] <= pBuf[i];
      end
    end
  end

  AST_PAGE_ROW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strb.bufWrite |=> $stable(addr[AW-1:PW])) else $error("page row moved"); // R6

  AST_READ_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdLoad && addr == AW'(DEPTH - 1)) |=> (addr == '0)) else $error("read wrap"); // R9

  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !pendAny) else $error("pending after commit"); // R5

endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int WR_CYCLES = 1000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    scl,
  input  logic    sdaIn,
  input  logic    devMatch,
  input  logic    devRead,
  input  logic    txBit,
  input  logic    pendAny,
  output strobe_t strb,
  output logic    sdaOe
);

  localparam int CW = $clog2(WR_CYCLES + 1);

  state_t        state, nxt;
  logic          sclQ, sdaQ;
  logic [3:0]    bitCnt;
  logic          mAck;
  logic [CW-1:0] busyCnt;

  logic sclRise, sclFall, startC, stopC;

  assign sclRise = scl && !sclQ;
  assign sclFall = !scl && sclQ;
  assign startC  = scl && sclQ && sdaQ && !sdaIn;
  assign stopC   = scl && sclQ && !sdaQ && sdaIn;

  always_comb begin
    nxt  = state;
    strb = '0;
    if (state == ST_BUSY) begin
      if (busyCnt == CW'(WR_CYCLES - 1)) nxt = ST_IDLE;
    end else if (startC) begin
      strb.clrBuf = 1'b1;
      nxt = ST_DEV;
    end else if (stopC) begin
      if (pendAny) begin
        strb.commit = 1'b1;
        nxt = ST_BUSY;
      end else begin
        nxt = ST_IDLE;
      end
    end else begin
      case (state)
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (sclRise && bitCnt < 4'd8) strb.rxShift = 1'b1;
          if (sclFall && bitCnt == 4'd8) begin
            if (state == ST_DEV) begin
              if (devMatch) begin
                strb.capDev = 1'b1;
                nxt = ST_DEVACK;
              end else begin
                nxt = ST_IDLE;
              end
            end else if (state == ST_WADR) begin
              strb.loadAddr = 1'b1;
              nxt = ST_WADRACK;
            end else begin
              strb.bufWrite = 1'b1;
              nxt = ST_WDATACK;
            end
          end
        end
        ST_DEVACK: begin
          if (sclFall) begin
            if (devRead) begin
              strb.rdLoad = 1'b1;
              nxt = ST_RDAT;
            end else begin
              nxt = ST_WADR;
            end
          end
        end
        ST_WADRACK, ST_WDATACK: begin
          if (sclFall) nxt = ST_WDAT;
        end
        ST_RDAT: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) nxt = ST_RACK;
            else strb.txShift = 1'b1;
          end
        end
        ST_RACK: begin
          if (sclFall) begin
            if (mAck) begin
              strb.rdLoad = 1'b1;
              nxt = ST_RDAT;
            end else begin
              nxt = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
      bitCnt  <= '0;
      mAck    <= 1'b0;
      busyCnt <= '0;
    end else begin
      state <= nxt;
      sclQ  <= scl;
      sdaQ  <= sdaIn;
      if (startC || nxt != state) bitCnt <= '0;
      else if (strb.rxShift || strb.txShift) bitCnt <= bitCnt + 1'b1;
      if (state == ST_RACK && sclRise) mAck <= !sdaIn;
      if (state == ST_BUSY) busyCnt <= busyCnt + 1'b1;
      else busyCnt <= '0;
    end
  end

  always_comb begin
    case (state)
      ST_DEVACK, ST_WADRACK, ST_WDATACK: sdaOe = 1'b1;
      ST_RDAT:                           sdaOe = !txBit;
      default:                           sdaOe = 1'b0;
    endcase
  end

  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY) |-> !sdaOe) else $error("drive while busy"); // R7

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY) |-> (busyCnt < CW'(WR_CYCLES))) else $error("busy overrun"); // R7

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !scl) else $error("drive began with clock high"); // R4

  AST_ACK_AFTER_EIGHT: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) && (state == ST_DEVACK || state == ST_WADRACK || state == ST_WDATACK))
      |-> ($past(bitCnt) == 4'd8)) else $error("ack before eight bits"); // R4

endmodule

// File: rtl/eeprom_slave.sv
module eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int SIZE_SEL  = 2,
  parameter int WR_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  logic [2:0] pinA,
  input  logic       wp,
  output logic       sdaOe
);

  strobe_t strb;
  logic    devMatch, devRead, txBit, pendAny;

  eeprom_ctrl #(.WR_CYCLES(WR_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn),
    .devMatch(devMatch), .devRead(devRead), .txBit(txBit), .pendAny(pendAny),
    .strb(strb), .sdaOe(sdaOe)
  );

  eeprom_dpath #(.SIZE_SEL(SIZE_SEL)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaIn(sdaIn), .pinA(pinA), .wp(wp),
    .devMatch(devMatch), .devRead(devRead), .txBit(txBit), .pendAny(pendAny)
  );

endmodule

// File: tb/tb_eeprom_slave.sv
module tb_eeprom_slave;

  localparam int CLK_PERIOD = 10;
  localparam int SIZE_SEL   = 2;
  localparam int WR_CYCLES  = 400;
  localparam int Q          = 4;
  localparam int NVEC       = 7;
  // {address, data}: written, waited out, then read back at random
  localparam logic [16:0] TBL [NVEC] = '{
    {9'h000, 8'hC3}, {9'h1FF, 8'h3C}, {9'h130, 8'h77}, {9'h0A5, 8'h5A},
    {9'h155, 8'hE1}, {9'h07F, 8'h08}, {9'h0FF, 8'h96}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic wp = 1'b0;
  logic [2:0] pinA = 3'b010;
  logic sdaOe;
  logic sdaLine;
  int nChecks = 0;
  int nFail = 0;
  logic done = 1'b0;

  assign sdaLine = sdaM & ~sdaOe;

  always #(CLK_PERIOD / 2) clk = ~clk;

  eeprom_slave #(.SIZE_SEL(SIZE_SEL), .WR_CYCLES(WR_CYCLES)) dut (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaLine),
    .pinA(pinA), .wp(wp), .sdaOe(sdaOe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] devByte(input logic page, input logic rd);
    return {4'b1010, pinA[2], pinA[1], page, rd};
  endfunction

  task automatic busStart();
    sdaM = 1'b1; tick(Q);
    scl = 1'b1;  tick(Q);
    sdaM = 1'b0; tick(Q);
    scl = 1'b0;  tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q);
    scl = 1'b1;  tick(Q);
    sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b;   tick(Q);
    scl = 1'b1; tick(2 * Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; tick(Q);
    scl = 1'b1;  tick(Q);
    ack = (sdaLine == 1'b0);
    tick(Q);
    scl = 1'b0;  tick(Q);
  endtask

  task automatic recvByte(input logic ackBit, output logic [7:0] d);
    sdaM = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      d = {d[6:0], sdaLine};
      tick(Q);
      scl = 1'b0;
    end
    tick(Q);
    sdaM = ackBit ? 1'b0 : 1'b1; tick(Q);
    scl = 1'b1; tick(2 * Q);
    scl = 1'b0; tick(Q);
    sdaM = 1'b1;
  endtask

  task automatic wrByte(input logic [8:0] a, input logic [7:0] d, output logic ok);
    logic k1, k2, k3;
    busStart();
    sendByte(devByte(a[8], 1'b0), k1);
    sendByte(a[7:0], k2);
    sendByte(d, k3);
    busStop();
    ok = k1 & k2 & k3;
  endtask

  task automatic rdRandom(input logic [8:0] a, output logic [7:0] d, output logic ok);
    logic k1, k2, k3;
    busStart();
    sendByte(devByte(a[8], 1'b0), k1);
    sendByte(a[7:0], k2);
    busStart();
    sendByte(devByte(1'b0, 1'b1), k3);
    recvByte(1'b0, d);
    busStop();
    ok = k1 & k2 & k3;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic ok, k;
    logic [7:0] d;

    // R14 reset state
    tick(5);
    chk("R14 sdaOe in reset", sdaOe, 0);
    rstN = 1'b1;
    tick(5);
    chk("R14 sdaOe after reset", sdaOe, 0);

    // R5 / R10 / R4: vector table walk
    for (int v = 0; v < NVEC; v++) begin
      wrByte(TBL[v][16:8], TBL[v][7:0], ok);
      chk("R4 write bytes acknowledged", ok, 1);
      tick(WR_CYCLES + 20);
      rdRandom(TBL[v][16:8], d, ok);
      chk("R10 random read acknowledged", ok, 1);
      chk("R5 byte write readback", d, TBL[v][7:0]);
    end

    // R3: select bit s0 is address bit 8, 0x1FF distinct from 0x0FF
    rdRandom(9'h1FF, d, ok);
    chk("R3 page bit separates 0x1FF from 0x0FF", d, 8'h3C);

    // R9: counter after reading 0x1FF wraps to 0x000
    busStart();
    sendByte(devByte(1'b0, 1'b1), k);
    chk("R9 current read acknowledged", k, 1);
    recvByte(1'b0, d);
    busStop();
    chk("R9 read wrap to byte 0", d, 8'hC3);

    // R2: wrong prefix and wrong strap
    busStart();
    sendByte(8'hB4, k);
    chk("R2 wrong prefix not acknowledged", k, 0);
    busStop();
    busStart();
    sendByte({4'b1010, ~pinA[2], pinA[1], 1'b0, 1'b0}, k);
    chk("R2 strap mismatch not acknowledged", k, 0);
    sendByte(8'h00, k);
    chk("R2 bytes after mismatch ignored", k, 0);
    busStop();

    // R1: START in the middle of a byte restarts address reception
    busStart();
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    busStart();
    sendByte(devByte(1'b0, 1'b0), k);
    chk("R1 restart mid-byte acknowledged", k, 1);
    busStop();

    // R12: STOP after word address only, no busy, address kept
    busStart();
    sendByte(devByte(1'b0, 1'b0), k);
    sendByte(8'hA5, k);
    busStop();
    busStart();
    sendByte(devByte(1'b0, 1'b1), k);
    chk("R12 no write cycle after empty STOP", k, 1);
    recvByte(1'b0, d);
    busStop();
    chk("R12 word address kept for current read", d, 8'h5A);

    // R7: busy window
    wrByte(9'h07F, 8'h19, ok);
    busStart();
    sendByte(devByte(1'b0, 1'b0), k);
    chk("R7 address refused during write cycle", k, 0);
    busStop();
    tick(WR_CYCLES + 20);
    busStart();
    sendByte(devByte(1'b0, 1'b0), k);
    chk("R7 address accepted after write cycle", k, 1);
    busStop();
    rdRandom(9'h07F, d, ok);
    chk("R7 committed data", d, 8'h19);

    // R8: write protect
    wp = 1'b1;
    wrByte(9'h0A5, 8'hEE, ok);
    chk("R8 protected write still acknowledged", ok, 1);
    tick(WR_CYCLES + 20);
    wp = 1'b0;
    rdRandom(9'h0A5, d, ok);
    chk("R8 array unchanged under protect", d, 8'h5A);

    // R13: data followed by repeated START is dropped
    busStart();
    sendByte(devByte(1'b1, 1'b0), k);
    sendByte(8'h55, k);
    sendByte(8'h00, k);
    busStart();
    sendByte(devByte(1'b0, 1'b1), k);
    recvByte(1'b0, d);
    busStop();
    rdRandom(9'h155, d, ok);
    chk("R13 no write cycle after repeated START", ok, 1);
    chk("R13 data discarded", d, 8'hE1);

    // R6 page write of 18 bytes from offset 0xE of row 0x120
    busStart();
    sendByte(devByte(1'b1, 1'b0), k);
    sendByte(8'h2E, k);
    for (int j = 0; j < 18; j++) sendByte(8'(8'h40 + j), k);
    busStop();
    tick(WR_CYCLES + 20);

    // R11 sequential read across the page end
    busStart();
    sendByte(devByte(1'b1, 1'b0), k);
    sendByte(8'h20, k);
    busStart();
    sendByte(devByte(1'b0, 1'b1), k);
    for (int j = 0; j < 17; j++) begin
      logic [7:0] e;
      recvByte(j < 16, d);
      if (j < 14) e = 8'(8'h42 + j);
      else if (j == 14) e = 8'h50;
      else if (j == 15) e = 8'h51;
      else e = 8'h77;
      if (j < 16) chk("R6 page wrap content", d, e);
      else chk("R11 sequential read crosses page", d, e);
    end
    tick(Q);
    chk("R11 SDA released after master NACK", sdaOe, 0);
    busStop();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule